// File: doc/BRIEF.md
# Pseudo-random line source with loop delay meter

This block drives a serial test line with a maximal-length pseudo-random bit stream and a matching bit clock. It also measures how many bit periods the stream takes to travel through an external system under test and come back. The generator is a 23-stage linear feedback shift register with feedback polynomial 1 + x^5 + x^23. It is advanced once per bit period, and the bit period is an integer number of system clocks. A push-button style request inverts exactly one outgoing bit, so the far-end checker sees one deliberate error.

A start strobe begins a delay measurement. The block collects the next 64 bits it puts on the line into a fixed reference pattern. It waits until its own transmit shift register agrees with that reference, and then counts bit periods. The count stops when the shift register built from the returned line holds the same 64 bits. The count then stays on `delay_count` with `delay_valid` high until the next start. If the pattern never returns, the counter saturates and raises an overflow flag.

The line interface runs at a fixed rate and cannot stall, so it carries no valid/ready pair and no back-pressure. The returned clock is sampled in the system clock domain. Every other pin is a plain control or status level.

Top module: `prbs_loop_meter`

## Requirements
- R1: The bit sampled on each rising edge of `tx_clk`, with no injection pending, satisfies b[n] = b[n-23] XOR b[n-5], and the stream is never all zeros.
- R2: `tx_clk` has a period of exactly CLKS_PER_BIT system clocks and is high for the second half of each bit. `tx_data` changes only on the system clock edge where `tx_clk` falls.
- R3: Each rising edge of `inject_req` inverts exactly one later transmitted bit, however long the request is held. A single-cycle pulse also inverts one bit.
- R4: When the returned line is the transmitted line delayed by K bit periods (1 <= K < 2^CNT_W), a measurement ends with `delay_count` = K and `delay_ovf` = 0.
- R5: `delay_valid` is 0 from the cycle after a start strobe until the measurement ends. After that it stays 1, with `delay_count` unchanged, until the next start.
- R6: If no match arrives, the count stops at 2^CNT_W-1 without wrapping, and `delay_ovf` and `delay_valid` both become 1. K = 2^CNT_W-1 still reports without overflow, and K = 2^CNT_W reports as overflow.
- R7: During reset, `tx_data`, `tx_clk`, `delay_valid`, `delay_ovf` and `delay_count` are all 0.
- R8: A start strobe during a running measurement discards it, clears `delay_valid`, and captures a new reference. The new result is the loop delay measured afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inject_req | input | 1 | Error-injection request (button level, synchronised inside) |
| start_req | input | 1 | Synchronous one-cycle strobe that starts a delay measurement |
| rx_data | input | 1 | Returned line data |
| rx_clk | input | 1 | Returned line clock, data sampled on its rising edge |
| tx_data | output | 1 | Outgoing test bit |
| tx_clk | output | 1 | Outgoing bit clock |
| delay_count | output | CNT_W | Measured loop delay in bit periods |
| delay_valid | output | 1 | Measurement finished, count is stable |
| delay_ovf | output | 1 | Count saturated without a match |

## Verification
The bench builds the block with CLKS_PER_BIT = 8, the smallest period for which the three-cycle receive synchroniser still lands inside the correct bit period. It uses CNT_W = 6, so saturation is reached after 63 bit periods and both sides of the overflow boundary (K = 63 and K = 64) can be tested in a short run. The 23-stage generator and the 64-bit pattern keep their default sizes, so the recurrence and the pattern uniqueness are tested as they will be used.

// File: rtl/plm_pkg.sv
package plm_pkg;

  typedef enum logic [2:0] {
    MS_IDLE  = 3'd0,
    MS_FILL  = 3'd1,
    MS_SEEK  = 3'd2,
    MS_COUNT = 3'd3,
    MS_DONE  = 3'd4
  } meter_state_e;

endpackage

// File: rtl/plm_bit_timer.sv
module plm_bit_timer #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_tick,
  output logic tx_clk
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_nxt;

  always_comb begin
    bit_tick  = (phase_q == CW'(CLKS_PER_BIT - 1));
    phase_nxt = bit_tick ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      tx_clk  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      tx_clk  <= (phase_nxt >= CW'(HALF));
    end
  end

  AST_CLK_HIGH_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> tx_clk); // R2
  AST_CLK_FALLS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !tx_clk); // R2

endmodule

// File: rtl/plm_lfsr.sv
module plm_lfsr #(
  parameter int LEN = 23,
  parameter int TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic bit_out
);
  logic [LEN-1:0] state_q;
  logic           feedback;

  assign feedback = state_q[LEN-1] ^ state_q[TAP-1];
  assign bit_out  = state_q[LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '1;
    else if (advance) state_q <= {state_q[LEN-2:0], feedback};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R1

endmodule

// File: rtl/plm_err_inject.sv
module plm_err_inject (
  input  logic clk,
  input  logic rst_n,
  input  logic inject_req,
  input  logic bit_tick,
  output logic flip_now
);
  logic s1, s2, s3;
  logic rise;
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= inject_req;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise     = s2 & ~s3;
  assign flip_now = pending_q & bit_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= (pending_q & ~bit_tick) | rise;
  end

  AST_FLIP_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    flip_now && !rise |=> !pending_q); // R3
  AST_NO_FLIP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q && !rise |=> !flip_now); // R3

endmodule

// File: rtl/plm_rx_front.sv
module plm_rx_front #(
  parameter int PAT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data,
  input  logic             rx_clk,
  output logic [PAT_W-1:0] rx_sr
);
  logic c1, c2, c3;
  logic d1, d2;
  logic sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= 1'b0;
      c2 <= 1'b0;
      c3 <= 1'b0;
      d1 <= 1'b0;
      d2 <= 1'b0;
    end else begin
      c1 <= rx_clk;
      c2 <= c1;
      c3 <= c2;
      d1 <= rx_data;
      d2 <= d1;
    end
  end

  assign sample = c2 & ~c3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_sr <= '0;
    else if (sample) rx_sr <= {rx_sr[PAT_W-2:0], d2};
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(c2 && !c3) |=> $stable(rx_sr)); // R4

endmodule

// File: rtl/plm_delay_meter.sv
module plm_delay_meter
  import plm_pkg::*;
#(
  parameter int PAT_W = 64,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             bit_tick,
  input  logic             tx_bit,
  input  logic [PAT_W-1:0] rx_sr,
  output logic [CNT_W-1:0] count,
  output logic             valid,
  output logic             ovf
);
  localparam int              FW   = $clog2(PAT_W + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  meter_state_e     state_q;
  logic [PAT_W-1:0] tx_sr;
  logic [PAT_W-1:0] ref_q;
  logic [FW-1:0]    fill_q;
  logic             tx_hit, rx_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_sr <= '0;
    else if (bit_tick) tx_sr <= {tx_sr[PAT_W-2:0], tx_bit};
  end

  assign tx_hit = (tx_sr == ref_q);
  assign rx_hit = (rx_sr == ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      ref_q   <= '0;
      fill_q  <= '0;
      count   <= '0;
      valid   <= 1'b0;
      ovf     <= 1'b0;
    end else if (start_req) begin
      state_q <= MS_FILL;
      fill_q  <= '0;
      count   <= '0;
      valid   <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      unique case (state_q)
        MS_IDLE: ;
        MS_FILL: begin
          if (fill_q == FW'(PAT_W)) begin
            ref_q   <= tx_sr;
            state_q <= MS_SEEK;
          end else if (bit_tick) begin
            fill_q <= fill_q + 1'b1;
          end
        end
        MS_SEEK: begin
          if (tx_hit) begin
            count   <= '0;
            state_q <= MS_COUNT;
          end
        end
        MS_COUNT: begin
          if (rx_hit) begin
            valid   <= 1'b1;
            state_q <= MS_DONE;
          end else if (bit_tick) begin
            if (count == CMAX) begin
              ovf     <= 1'b1;
              valid   <= 1'b1;
              state_q <= MS_DONE;
            end else begin
              count <= count + 1'b1;
            end
          end
        end
        MS_DONE: ;
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !start_req |=> valid); // R5
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !start_req |=> $stable(count)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX) && !start_req |=> (count == CMAX)); // R6
  AST_OVF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> valid); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !valid && !ovf && (count == '0)); // R8

endmodule

// File: rtl/prbs_loop_meter.sv
module prbs_loop_meter #(
  parameter int CLKS_PER_BIT = 16,
  parameter int LFSR_LEN     = 23,
  parameter int LFSR_TAP     = 5,
  parameter int PAT_W        = 64,
  parameter int CNT_W        = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inject_req,
  input  logic             start_req,
  input  logic             rx_data,
  input  logic             rx_clk,
  output logic             tx_data,
  output logic             tx_clk,
  output logic [CNT_W-1:0] delay_count,
  output logic             delay_valid,
  output logic             delay_ovf
);
  logic             bit_tick;
  logic             gen_bit;
  logic             flip_now;
  logic             tx_bit_nxt;
  logic [PAT_W-1:0] rx_sr;

  plm_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_clk(tx_clk)
  );

  plm_lfsr #(.LEN(LFSR_LEN), .TAP(LFSR_TAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(bit_tick), .bit_out(gen_bit)
  );

  plm_err_inject u_inject (
    .clk(clk), .rst_n(rst_n), .inject_req(inject_req),
    .bit_tick(bit_tick), .flip_now(flip_now)
  );

  assign tx_bit_nxt = gen_bit ^ flip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_data <= 1'b0;
    else if (bit_tick) tx_data <= tx_bit_nxt;
  end

  plm_rx_front #(.PAT_W(PAT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_clk(rx_clk), .rx_sr(rx_sr)
  );

  plm_delay_meter #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bit_tick(bit_tick),
    .tx_bit(tx_bit_nxt), .rx_sr(rx_sr),
    .count(delay_count), .valid(delay_valid), .ovf(delay_ovf)
  );

  AST_TX_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_data)); // R2

endmodule

// File: tb/test_prbs_loop_meter.sv
module test_prbs_loop_meter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 8;
  localparam int CNT_W = 6;
  localparam int PAT_W = 64;
  localparam int LEN   = 23;
  localparam int TAP   = 5;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, inject_req = 1'b0, start_req = 1'b0, rx_data = 1'b0;
  logic rx_clk, tx_data, tx_clk, delay_valid, delay_ovf;
  logic [CNT_W-1:0] delay_count;

  int n_checks = 0, n_err = 0, cyc = 0;
  int loop_k = 1;
  bit loop_on = 1'b1;
  logic [127:0] hist = '0;
  int rec [0:511];
  int rec_n = 0;
  bit rec_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rx_clk = tx_clk;

  prbs_loop_meter #(.CLKS_PER_BIT(DIV), .LFSR_LEN(LEN), .LFSR_TAP(TAP),
                    .PAT_W(PAT_W), .CNT_W(CNT_W)) i_prbs_loop_meter (
    .clk(clk), .rst_n(rst_n), .inject_req(inject_req), .start_req(start_req),
    .rx_data(rx_data), .rx_clk(rx_clk), .tx_data(tx_data), .tx_clk(tx_clk),
    .delay_count(delay_count), .delay_valid(delay_valid), .delay_ovf(delay_ovf));

  // external loop: K bit periods of delay
  always @(posedge tx_clk) begin
    hist = {hist[126:0], tx_data};
    if (rec_en && rec_n < 512) begin
      rec[rec_n] = int'(tx_data);
      rec_n++;
    end
  end
  always @(negedge tx_clk) rx_data = loop_on ? hist[loop_k-1] : 1'b0;

  // line timing monitor (R2)
  logic prev_d = 1'b0, prev_c = 1'b0;
  int since_rise = 0, rises = 0, r2_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (tx_data !== prev_d && !(prev_c && !tx_clk)) r2_bad++;
    since_rise++;
    if (tx_clk && !prev_c) begin
      if (rises > 0 && since_rise != DIV) r2_bad++;
      since_rise = 0;
      rises++;
    end
    prev_d = tx_data;
    prev_c = tx_clk;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  // bits that differ from the pure recurrence seeded by the first LEN bits
  function automatic int recurrence_misses(int n);
    int pred [0:511];
    int miss = 0;
    for (int t = 0; t < n; t++) begin
      if (t < LEN) pred[t] = rec[t];
      else begin
        pred[t] = pred[t-LEN] ^ pred[t-TAP];
        if (pred[t] != rec[t]) miss++;
      end
    end
    return miss;
  endfunction

  task automatic record_bits(int nb, int inj_a, int inj_b, int hold);
    rec_n = 0;
    rec_en = 1'b1;
    fork
      wait (rec_n >= nb);
      begin
        if (inj_a > 0) begin
          wait (rec_n == inj_a); @(negedge clk);
          inject_req = 1'b1; repeat (hold) @(negedge clk); inject_req = 1'b0;
        end
        if (inj_b > 0) begin
          wait (rec_n == inj_b); @(negedge clk);
          inject_req = 1'b1; repeat (hold) @(negedge clk); inject_req = 1'b0;
        end
      end
    join
    rec_en = 1'b0;
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < (PAT_W + CMAX + 200) * DIV; i++) begin
      if (delay_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(int k, bit lp, output int cnt, output bit ov, output bit seen);
    loop_k = k;
    loop_on = lp;
    repeat (16 * DIV) @(negedge clk);
    pulse_start();
    check(delay_valid == 1'b0, "R5 valid low after start", int'(delay_valid), 0);
    wait_valid(seen);
    cnt = int'(delay_count);
    ov = delay_ovf;
  endtask

  initial begin
    int cnt, k0;
    bit ov, seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7 reset values
    check(tx_data == 1'b0, "R7 tx_data", int'(tx_data), 0);
    check(tx_clk == 1'b0, "R7 tx_clk", int'(tx_clk), 0);
    check(delay_valid == 1'b0, "R7 delay_valid", int'(delay_valid), 0);
    check(delay_ovf == 1'b0, "R7 delay_ovf", int'(delay_ovf), 0);
    check(delay_count == '0, "R7 delay_count", int'(delay_count), 0);
    rst_n = 1'b1;
    repeat (40 * DIV) @(negedge clk);

    // R1 clean sequence
    record_bits(300, 0, 0, 0);
    check(recurrence_misses(300) == 0, "R1 recurrence", recurrence_misses(300), 0);
    begin
      int ones = 0;
      for (int t = 0; t < 300; t++) ones += rec[t];
      check(ones > 0 && ones < 300, "R1 mixed bits", ones, 150);
    end

    // R3 two held presses, then one single-cycle pulse
    record_bits(300, 40, 120, 30 * DIV);
    check(recurrence_misses(300) == 2, "R3 held presses", recurrence_misses(300), 2);
    record_bits(200, 50, 0, 1);
    check(recurrence_misses(200) == 1, "R3 short pulse", recurrence_misses(200), 1);

    // R4 directed and random loop delays
    measure(1, 1'b1, cnt, ov, seen);
    check(seen && cnt == 1 && !ov, "R4 K=1", cnt, 1);
    for (int i = 0; i < 8; i++) begin
      k0 = int'($urandom_range(50, 2));
      measure(k0, 1'b1, cnt, ov, seen);
      check(seen && cnt == k0 && !ov, "R4 random K", cnt, k0);
    end

    // R5 result held
    cnt = int'(delay_count);
    repeat (300) @(negedge clk);
    check(delay_valid == 1'b1, "R5 valid held", int'(delay_valid), 1);
    check(int'(delay_count) == cnt, "R5 count held", int'(delay_count), cnt);

    // R6 boundary and open loop
    measure(CMAX, 1'b1, cnt, ov, seen);
    check(seen && cnt == CMAX && !ov, "R6 K=max no overflow", cnt, CMAX);
    measure(CMAX + 1, 1'b1, cnt, ov, seen);
    check(seen && cnt == CMAX && ov, "R6 K=max+1 overflow", cnt, CMAX);
    measure(5, 1'b0, cnt, ov, seen);
    check(seen && ov, "R6 open loop overflow flag", int'(ov), 1);
    check(cnt == CMAX, "R6 open loop count", cnt, CMAX);

    // R8 restart mid-measurement
    loop_k = 30;
    loop_on = 1'b1;
    repeat (16 * DIV) @(negedge clk);
    pulse_start();
    repeat (70 * DIV) @(negedge clk);
    pulse_start();
    check(delay_valid == 1'b0, "R8 valid cleared by restart", int'(delay_valid), 0);
    repeat (60 * DIV) @(negedge clk);
    check(delay_valid == 1'b0, "R8 no early result", int'(delay_valid), 0);
    wait_valid(seen);
    check(seen && int'(delay_count) == 30 && !delay_ovf, "R8 restart result", int'(delay_count), 30);

    check(r2_bad == 0 && rises > 100, "R2 line timing", r2_bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule